// File: doc/BRIEF.md
# Forced Branch-and-Store Interrupt Entry Sequencer

The block carries out the entry into an interrupt handler that the processor forces once a winning priority level has been chosen elsewhere. When the instruction in flight has finished, it receives that level and the current instruction address. It fetches the level's vector word from a fixed slot in word-addressed memory and treats that word as an effective address (EA). It writes the saved instruction address into memory at the EA. It then loads the instruction address register with EA+1, so the handler's first instruction comes from the word after the saved return address.

The block talks to memory through a simple synchronous port. Read data returns one cycle after the request. The block has a start/done handshake and a one-cycle IAR load strobe. Priority arbitration, instruction decode and the return branch sit in neighbouring blocks.

Top module: `irq_entry_seq`

## Requirements
- R1: The vector word for level N (0 to 5) is read from memory address 8+N. The read request is on the port in the first cycle after the request is accepted.
- R2: The word returned by that read is the EA. The later memory write goes to exactly that address.
- R3: The data written at the EA is the value of `iar_i` in the cycle the request was accepted.
- R4: `iar_load_o` pulses for one cycle with `iar_next_o` equal to EA+1, modulo 2^16, so EA 16'hFFFF gives 16'h0000.
- R5: The steps follow a fixed order, counted in cycles after acceptance: read in cycle 1, write in cycle 3, IAR load in cycle 4, `done_o` in cycle 5 for exactly one cycle. `busy_o` is high in cycles 1 to 5 and low afterwards.
- R6: A start request made while the sequencer is busy is ignored. It causes no extra memory access and no extra done pulse.
- R7: A start request is accepted only in a cycle where `insn_done_i` is high, meaning the current instruction has fully completed. Otherwise it is ignored.
- R8: A start request with a level of 6 or 7 is ignored and causes no memory access.
- R9: After reset, `mem_req_o`, `iar_load_o`, `busy_o` and `done_o` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to perform the forced entry |
| insn_done_i | input | 1 | High when the current instruction has fully completed |
| level_i | input | 3 | Winning interrupt level, 0 to 5 |
| iar_i | input | 16 | Current instruction address (the return address) |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | 16 | Word address |
| mem_wdata_o | output | 16 | Write data |
| mem_rdata_i | input | 16 | Read data, valid the cycle after a read request |
| iar_load_o | output | 1 | One-cycle strobe to load the IAR |
| iar_next_o | output | 16 | New IAR value (EA+1) |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every level from 0 to 5 is run, each with several vector and return-address pairs. These runs separate a wrong vector slot from a wrong EA and from a swapped address and data. They include a handler at 16'h0600 with a return address of 16'h0502, which must leave 16'h0502 at 16'h0600 and an IAR of 16'h0601. A vector of 16'hFFFF exercises the wrap of EA+1. Requests are also held through a whole sequence, raised before the instruction has completed, and raised with levels 6 and 7. In each of these cases the memory port must stay quiet and only one done pulse may appear.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  // Sequencer steps; the order is the behaviour.
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_FETCH = 3'd1,
    ST_LATCH = 3'd2,
    ST_SAVE  = 3'd3,
    ST_JUMP  = 3'd4,
    ST_FIN   = 3'd5
  } entry_state_e;

endpackage

// File: rtl/irq_entry_gate.sv
module irq_entry_gate #(
  parameter int NUM_LEVELS = 6,
  parameter int LVL_W      = 3
) (
  input  logic             start_i,
  input  logic             insn_done_i,
  input  logic             idle_i,
  input  logic [LVL_W-1:0] level_i,
  output logic             accept_o
);

  // Level range test kept as a function so the bench can restate it.
  function automatic logic level_in_range(input logic [LVL_W-1:0] lvl);
    return int'(lvl) < NUM_LEVELS;
  endfunction

  logic lvl_ok;

  always_comb begin
    lvl_ok   = level_in_range(level_i);
    accept_o = start_i && insn_done_i && idle_i && lvl_ok;
  end

endmodule

// File: rtl/irq_entry_ctl.sv
module irq_entry_ctl
  import irq_entry_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic accept_i,
  output logic idle_o,
  output logic rd_vec_o,
  output logic cap_ea_o,
  output logic wr_ret_o,
  output logic load_iar_o,
  output logic done_o,
  output logic busy_o
);

  entry_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept_i) state_d = ST_FETCH;
      ST_FETCH: state_d = ST_LATCH;
      ST_LATCH: state_d = ST_SAVE;
      ST_SAVE:  state_d = ST_JUMP;
      ST_JUMP:  state_d = ST_FIN;
      ST_FIN:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_comb begin
    idle_o     = (state_q == ST_IDLE);
    rd_vec_o   = (state_q == ST_FETCH);
    cap_ea_o   = (state_q == ST_LATCH);
    wr_ret_o   = (state_q == ST_SAVE);
    load_iar_o = (state_q == ST_JUMP);
    done_o     = (state_q == ST_FIN);
    busy_o     = !idle_o;
  end

  // R5: each step strictly follows its predecessor
  a_r5_latch_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ea_o |-> $past(rd_vec_o));
  a_r5_fin_after_jump: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> $past(load_iar_o));
  a_r5_one_step: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_vec_o, cap_ea_o, wr_ret_o, load_iar_o, done_o}));

endmodule

// File: rtl/irq_entry_dp.sv
module irq_entry_dp #(
  parameter int AW         = 16,
  parameter int VEC_BASE   = 8,
  parameter int LVL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             accept_i,
  input  logic             rd_vec_i,
  input  logic             cap_ea_i,
  input  logic             wr_ret_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [AW-1:0]    iar_i,
  input  logic [AW-1:0]    rdata_i,
  output logic [AW-1:0]    addr_o,
  output logic [AW-1:0]    wdata_o,
  output logic [AW-1:0]    iar_next_o
);

  // Vector slot address for a level.
  function automatic logic [AW-1:0] vector_slot(input logic [LVL_W-1:0] lvl);
    return AW'(VEC_BASE + int'(lvl));
  endfunction

  // Handler start: word after the saved return address, wrapping.
  function automatic logic [AW-1:0] handler_start(input logic [AW-1:0] ea);
    return ea + AW'(1);
  endfunction

  logic [LVL_W-1:0] lvl_q;
  logic [AW-1:0]    ret_q;
  logic [AW-1:0]    ea_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl_q <= '0;
      ret_q <= '0;
    end else if (accept_i) begin
      lvl_q <= level_i;
      ret_q <= iar_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ea_q <= '0;
    else if (cap_ea_i) ea_q <= rdata_i;
  end

  always_comb begin
    addr_o     = rd_vec_i ? vector_slot(lvl_q) : (wr_ret_i ? ea_q : '0);
    wdata_o    = wr_ret_i ? ret_q : '0;
    iar_next_o = handler_start(ea_q);
  end

  // R2: the address written is the word read back one cycle earlier
  a_r2_ea_from_read: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ret_i |-> addr_o == $past(rdata_i));

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq #(
  parameter int AW         = 16,
  parameter int VEC_BASE   = 8,
  parameter int NUM_LEVELS = 6,
  parameter int LVL_W      = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             insn_done_i,
  input  logic [LVL_W-1:0] level_i,
  input  logic [AW-1:0]    iar_i,
  output logic             mem_req_o,
  output logic             mem_we_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [AW-1:0]    mem_wdata_o,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             iar_load_o,
  output logic [AW-1:0]    iar_next_o,
  output logic             busy_o,
  output logic             done_o
);

  // Named internal events
  logic accept_w;
  logic idle_w;
  logic rd_vec_w;
  logic cap_ea_w;
  logic wr_ret_w;
  logic load_w;

  irq_entry_gate #(
    .NUM_LEVELS (NUM_LEVELS),
    .LVL_W      (LVL_W)
  ) u_gate (
    .start_i     (start_i),
    .insn_done_i (insn_done_i),
    .idle_i      (idle_w),
    .level_i     (level_i),
    .accept_o    (accept_w)
  );

  irq_entry_ctl u_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept_w),
    .idle_o     (idle_w),
    .rd_vec_o   (rd_vec_w),
    .cap_ea_o   (cap_ea_w),
    .wr_ret_o   (wr_ret_w),
    .load_iar_o (load_w),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  irq_entry_dp #(
    .AW       (AW),
    .VEC_BASE (VEC_BASE),
    .LVL_W    (LVL_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .accept_i   (accept_w),
    .rd_vec_i   (rd_vec_w),
    .cap_ea_i   (cap_ea_w),
    .wr_ret_i   (wr_ret_w),
    .level_i    (level_i),
    .iar_i      (iar_i),
    .rdata_i    (mem_rdata_i),
    .addr_o     (mem_addr_o),
    .wdata_o    (mem_wdata_o),
    .iar_next_o (iar_next_o)
  );

  always_comb begin
    mem_req_o  = rd_vec_w || wr_ret_w;
    mem_we_o   = wr_ret_w;
    iar_load_o = load_w;
  end

  // R1: reads only hit the vector table
  a_r1_vec_window: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |->
      (int'(mem_addr_o) >= VEC_BASE && int'(mem_addr_o) < VEC_BASE + NUM_LEVELS));
  // R1: a read comes right after an accepted request
  a_r1_read_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && !mem_we_o) |-> $past(accept_w));
  // R3: written data is the IAR seen at acceptance
  a_r3_saved_iar: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> (mem_wdata_o == $past(iar_i, 3)));
  // R5: write two cycles after the vector read
  a_r5_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_o && mem_we_o) |-> $past(mem_req_o && !mem_we_o, 2));
  // R4: new IAR is the written address plus one
  a_r4_next_after_ea: assert property (@(posedge clk) disable iff (!rst_n)
    iar_load_o |-> (iar_next_o == $past(mem_addr_o) + AW'(1)) && $past(mem_req_o && mem_we_o));
  // R6: no acceptance while busy
  a_r6_quiet_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |=> !(mem_req_o && !mem_we_o) || $past(done_o));

endmodule

// File: tb/tb_irq_entry_seq.sv
module tb_irq_entry_seq;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i, insn_done_i;
  logic [2:0]  level_i;
  logic [15:0] iar_i;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o, mem_wdata_o, mem_rdata_i;
  logic        iar_load_o;
  logic [15:0] iar_next_o;
  logic        busy_o, done_o;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  irq_entry_seq dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .insn_done_i(insn_done_i),
    .level_i(level_i), .iar_i(iar_i), .mem_req_o(mem_req_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
    .iar_load_o(iar_load_o), .iar_next_o(iar_next_o), .busy_o(busy_o), .done_o(done_o)
  );

  // Sparse memory model
  logic [15:0] mem [logic [15:0]];

  always @(posedge clk) begin
    if (mem_req_o && mem_we_o) mem[mem_addr_o] = mem_wdata_o;
    if (mem_req_o && !mem_we_o)
      mem_rdata_i <= mem.exists(mem_addr_o) ? mem[mem_addr_o] : 16'h0000;
  end

  function automatic logic [15:0] rd(input logic [15:0] a);
    return mem.exists(a) ? mem[a] : 16'h0000;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One entry; hold_start keeps the request up (other level) through the run.
  task automatic run_entry(input int lvl, input logic [15:0] ret,
                           input logic [15:0] vec, input bit hold_start);
    int rd_cyc = -1, wr_cyc = -1, ld_cyc = -1, dn_cyc = -1;
    int n_rd = 0, n_dn = 0;
    logic [15:0] rd_addr = '0, wr_addr = '0, wr_data = '0, nxt = '0;
    mem[16'(8 + lvl)] = vec;
    @(negedge clk);
    start_i = 1'b1; insn_done_i = 1'b1; level_i = 3'(lvl); iar_i = ret;
    for (int i = 1; i <= 9; i++) begin
      @(posedge clk); @(negedge clk);
      if (mem_req_o && !mem_we_o) begin n_rd++; rd_cyc = i; rd_addr = mem_addr_o; end
      if (mem_req_o && mem_we_o) begin wr_cyc = i; wr_addr = mem_addr_o; wr_data = mem_wdata_o; end
      if (iar_load_o) begin ld_cyc = i; nxt = iar_next_o; end
      if (done_o) begin n_dn++; dn_cyc = i; end
      if (i <= 5) chk("R5 busy during run", 32'(busy_o), 32'd1);
      if (i == 6) chk("R5 busy cleared", 32'(busy_o), 32'd0);
      if (!hold_start || i >= 5) begin
        start_i = 1'b0; iar_i = 16'hDEAD;
      end else begin
        level_i = 3'((lvl + 1) % 6); iar_i = ret ^ 16'h5A5A;
      end
    end
    chk("R1 vector slot", 32'(rd_addr), 32'(8 + lvl));
    chk("R1 read cycle", rd_cyc, 1);
    chk("R2 write to EA", 32'(wr_addr), 32'(vec));
    chk("R3 saved IAR", 32'(wr_data), 32'(ret));
    chk("R3 memory at EA", 32'(rd(vec)), 32'(ret));
    chk("R4 new IAR", 32'(nxt), 32'((32'(vec) + 1) % 65536));
    chk("R5 order", {8'(wr_cyc), 8'(ld_cyc), 8'(dn_cyc)}, {8'd3, 8'd4, 8'd5});
    chk("R6 single read", n_rd, 1);
    chk("R6 single done", n_dn, 1);
  endtask

  // Request that must be ignored: no memory request, no busy, no done.
  task automatic run_ignored(input string req, input int lvl, input logic ins_done);
    int act = 0;
    @(negedge clk);
    start_i = 1'b1; insn_done_i = ins_done; level_i = 3'(lvl); iar_i = 16'h1234;
    for (int i = 1; i <= 6; i++) begin
      @(posedge clk); @(negedge clk);
      if (mem_req_o || busy_o || done_o || iar_load_o) act++;
    end
    start_i = 1'b0; insn_done_i = 1'b1;
    chk(req, act, 0);
  endtask

  initial begin
    start_i = 0; insn_done_i = 0; level_i = 0; iar_i = 0; rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    chk("R9 reset outputs", {mem_req_o, iar_load_o, busy_o, done_o}, 4'b0000);
    rst_n = 1;
    @(negedge clk);

    run_entry(0, 16'h0502, 16'h0600, 1'b0);
    for (int l = 0; l < 6; l++) begin
      run_entry(l, 16'(16'h0100 * l + 7), 16'(16'h2000 + 16'h0111 * l), 1'b0);
      run_entry(l, 16'hFFFE - 16'(l), 16'(16'h0040 + l * 3), 1'b0);
    end
    run_entry(3, 16'hABCD, 16'hFFFF, 1'b0);   // R4 wrap
    run_entry(4, 16'h1500, 16'h0020, 1'b1);   // R6 held request while busy
    run_ignored("R7 instruction not complete", 2, 1'b0);
    run_ignored("R8 level 6", 6, 1'b1);
    run_ignored("R8 level 7", 7, 1'b1);
    run_entry(5, 16'h0777, 16'h3000, 1'b0);   // still works afterwards

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule